// File: doc/BRIEF.md
# Multi-Lane ADC Word Serializer with Bit and Frame Clocks

This block takes one parallel sample word per ADC channel and shifts the words out on a set of serial lanes, one bit per cycle of a fast clock that runs at the serial bit rate. Two timing outputs travel with the data. The first is a bit clock that toggles every cycle, so each data bit sits in one half-period of it and can be captured on both of its edges. The second is a frame clock that marks where each word frame begins.

Run-time controls set three things. They pick a word size of 10, 12, 14 or 16 bits. They pick the bit order. They pick a packing mode. In single-rate packing every lane carries one channel. In double-rate packing one lane carries the words of two adjacent channels back to back within one frame. Half of the lanes then fall idle and raise a power-down flag.

Controls and sample words are taken only at a frame boundary. A downstream receiver therefore never sees a frame that mixes two settings.

Top module: `adc_lane_serializer`

## Requirements
- R1: `word_sel` selects the word size: 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16. In single-rate packing one frame lasts exactly that many cycles.
- R2: With `msb_first` low, word bit 0 goes out first. With `msb_first` high, bit W-1 goes out first, where W is the selected word size.
- R3: With `dual_rate` low, lane n carries the word of channel n for every lane, and every bit of `lane_pd` is low.
- R4: With `dual_rate` high, a frame lasts 2W cycles. Lanes 0 to 3 carry the channel pairs (0,1), (2,3), (4,5) and (6,7). Lanes 8 to 11 carry (8,9), (10,11), (12,13) and (14,15). The lower-numbered channel of each pair goes out first, followed at once by the higher-numbered one.
- R5: With `dual_rate` high, lanes 4 to 7 and 12 to 15 drive a constant 0 and their `lane_pd` bits are high.
- R6: `bclk_out` toggles on every cycle while the block runs. It is high while an even-numbered bit of the frame is on the lanes, including bit 0.
- R7: `fclk_out` is high for the first half of the bits of each frame and low for the second half. It rises with the first bit of every frame.
- R8: Sample words, word size, bit order and packing mode are captured only at the start of a frame. Changes made during a frame have no effect on that frame.
- R9: `rst` is synchronous and active high. While it is asserted, all outputs are 0. The first bit of the first frame appears after the second rising clock edge with `rst` low.
- R10: Word bits at or above the selected word size never reach any lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| words_in | input | NUM_CH*16 | Channel words; channel c occupies bits [16c+15:16c] |
| word_sel | input | 2 | Word size select (10/12/14/16 bits) |
| msb_first | input | 1 | 1 = most significant bit first |
| dual_rate | input | 1 | 1 = two channel words per lane |
| lane_out | output | NUM_CH | Serial data, one bit per lane |
| lane_pd | output | NUM_CH | Per-lane power-down flag for idle lanes |
| bclk_out | output | 1 | Bit clock, toggling each cycle |
| fclk_out | output | 1 | Frame clock |

## Verification
The bench builds the block with the default 16 channels. This gives two lane groups of eight, so the lane-to-pin remap and the idle pattern of double-rate packing are exercised in both halves of the output bus. All four word sizes are run in both packing modes and both bit orders. Settings and words are changed at random cycles inside frames, which puts the frame-boundary capture to the test. A reset pulse in the middle of the run checks the restart timing.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam int MIN_W  = 10;
  localparam int W_STEP = 2;
  localparam int MAX_W  = MIN_W + 3 * W_STEP;
  localparam int CNT_W  = $clog2(2 * MAX_W);
  localparam int IDX_W  = $clog2(MAX_W);

  typedef struct packed {
    logic [1:0] wsel;
    logic       msb;
    logic       dual;
  } ser_cfg_t;

  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] sel);
    return CNT_W'(MIN_W + W_STEP * int'(sel));
  endfunction
endpackage

// File: rtl/adc_ser_frame_ctrl.sv
module adc_ser_frame_ctrl
  import adc_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ser_cfg_t         cfg_in,
  output ser_cfg_t         cfg_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             boot_q,
  output logic             start,
  output logic             bclk_q,
  output logic             fclk_q
);
  logic [CNT_W-1:0] wlen, last, half;

  always_comb begin
    wlen  = word_bits(cfg_q.wsel);
    last  = cfg_q.dual ? (wlen << 1) - 1'b1 : wlen - 1'b1;
    half  = cfg_q.dual ? wlen : (wlen >> 1);
    start = boot_q || (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q <= 1'b1;
      cnt_q  <= '0;
      cfg_q  <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      if (!boot_q) begin
        bclk_q <= ~cnt_q[0];
        fclk_q <= (cnt_q < half);
      end
      if (start) begin
        cnt_q  <= '0;
        cfg_q  <= cfg_in;
        boot_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_ser_word_bank.sv
module adc_ser_word_bank #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_CH*WORD_W-1:0] words_in,
  output logic [NUM_CH*WORD_W-1:0] words_q
);
  always_ff @(posedge clk) begin
    if (rst)       words_q <= '0;
    else if (load) words_q <= words_in;
  end
endmodule

// File: rtl/adc_ser_lane_cell.sv
module adc_ser_lane_cell
  import adc_ser_pkg::*;
#(
  parameter bit PAIR_ACTIVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  ser_cfg_t         cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [MAX_W-1:0] word_own,
  input  logic [MAX_W-1:0] word_lo,
  input  logic [MAX_W-1:0] word_hi,
  output logic             bit_q,
  output logic             pd_q
);
  logic [CNT_W-1:0] wlen, pos, idx;
  logic [MAX_W-1:0] src;
  logic             second, idle, nxt_bit;

  always_comb begin
    wlen    = word_bits(cfg.wsel);
    second  = cfg.dual && (cnt >= wlen);
    pos     = second ? cnt - wlen : cnt;
    idx     = cfg.msb ? wlen - 1'b1 - pos : pos;
    src     = !cfg.dual ? word_own : (second ? word_hi : word_lo);
    idle    = cfg.dual && !PAIR_ACTIVE;
    nxt_bit = idle ? 1'b0 : src[idx[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      pd_q  <= 1'b0;
    end else if (!hold) begin
      bit_q <= nxt_bit;
      pd_q  <= idle;
    end
  end
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import adc_ser_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*MAX_W-1:0] words_in,
  input  logic [1:0]              word_sel,
  input  logic                    msb_first,
  input  logic                    dual_rate,
  output logic [NUM_CH-1:0]       lane_out,
  output logic [NUM_CH-1:0]       lane_pd,
  output logic                    bclk_out,
  output logic                    fclk_out
);
  localparam int GRP = NUM_CH / 2;

  ser_cfg_t                cfg_in, cfg_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    boot_q, start;
  logic [NUM_CH*MAX_W-1:0] words_q;

  assign cfg_in = '{wsel: word_sel, msb: msb_first, dual: dual_rate};

  adc_ser_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_q(cfg_q), .cnt_q(cnt_q),
    .boot_q(boot_q), .start(start), .bclk_q(bclk_out), .fclk_q(fclk_out)
  );

  adc_ser_word_bank #(.NUM_CH(NUM_CH), .WORD_W(MAX_W)) u_bank (
    .clk(clk), .rst(rst), .load(start), .words_in(words_in), .words_q(words_q)
  );

  for (genvar ln = 0; ln < NUM_CH; ln++) begin : g_lane
    localparam bit ACT = (ln % GRP) < (GRP / 2);
    localparam int LO  = ACT ? (ln / GRP) * GRP + 2 * (ln % GRP) : ln;
    localparam int HI  = ACT ? LO + 1 : ln;
    adc_ser_lane_cell #(.PAIR_ACTIVE(ACT)) u_cell (
      .clk(clk), .rst(rst), .hold(boot_q), .cfg(cfg_q), .cnt(cnt_q),
      .word_own(words_q[ln*MAX_W +: MAX_W]),
      .word_lo(words_q[LO*MAX_W +: MAX_W]),
      .word_hi(words_q[HI*MAX_W +: MAX_W]),
      .bit_q(lane_out[ln]), .pd_q(lane_pd[ln])
    );
  end
endmodule

// File: rtl/adc_ser_checker.sv
module adc_ser_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] lane_out,
  input logic [NUM_CH-1:0] lane_pd,
  input logic              bclk_out,
  input logic              fclk_out
);
  localparam int GRP = NUM_CH / 2;

  function automatic logic [NUM_CH-1:0] idle_mask();
    logic [NUM_CH-1:0] m;
    for (int i = 0; i < NUM_CH; i++) m[i] = (i % GRP) >= (GRP / 2);
    return m;
  endfunction
  localparam logic [NUM_CH-1:0] IDLE = idle_mask();

  p_bclk_fall_r6: assert property (@(posedge clk) disable iff (rst)
    bclk_out |=> !bclk_out);
  p_bclk_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (!bclk_out && fclk_out) |=> bclk_out);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (lane_pd & lane_out) == '0);
  p_pd_pattern_r5: assert property (@(posedge clk) disable iff (rst)
    (lane_pd == '0) || (lane_pd == IDLE));
  p_frame_on_bit0_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fclk_out) |-> bclk_out);
  p_mode_at_frame_r8: assert property (@(posedge clk) disable iff (rst)
    !$rose(fclk_out) |-> $stable(lane_pd));
endmodule

bind adc_lane_serializer adc_ser_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/adc_lane_serializer_bench.sv
`timescale 1ns/1ps
module adc_lane_serializer_bench;
  localparam int NC = 16;
  localparam int WW = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [NC*WW-1:0]  words_in;
  logic [1:0]        word_sel;
  logic              msb_first, dual_rate;
  logic [NC-1:0]     lane_out, lane_pd;
  logic              bclk_out, fclk_out;

  adc_lane_serializer #(.NUM_CH(NC)) u_adc_lane_serializer (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit        m_boot;
  int        m_cnt;
  int        m_sel;
  bit        m_msb, m_dual;
  logic [WW-1:0] m_words [NC];
  logic [NC-1:0] e_lane, e_pd;
  bit        e_bclk, e_fclk, e_reset;

  function automatic int flen(int sel, bit dual);
    int w = 10 + 2 * sel;
    return dual ? 2 * w : w;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_boot = 1; m_cnt = 0; m_sel = 0; m_msb = 0; m_dual = 0;
      foreach (m_words[k]) m_words[k] = '0;
      e_lane = '0; e_pd = '0; e_bclk = 0; e_fclk = 0; e_reset = 1;
      return;
    end
    if (!m_boot) begin
      int w = 10 + 2 * m_sel;
      e_reset = 0;
      e_bclk = (m_cnt % 2) == 0;
      e_fclk = m_cnt < flen(m_sel, m_dual) / 2;
      for (int i = 0; i < NC; i++) begin
        int ch, pos;
        if (!m_dual) begin
          ch = i; pos = m_cnt; e_pd[i] = 0;
        end else if ((i % (NC/2)) >= NC/4) begin
          e_pd[i] = 1; e_lane[i] = 0; continue;
        end else begin
          e_pd[i] = 0;
          ch  = (i / (NC/2)) * (NC/2) + 2 * (i % (NC/2)) + (m_cnt >= w ? 1 : 0);
          pos = m_cnt % w;
        end
        e_lane[i] = m_words[ch][m_msb ? (w - 1 - pos) : pos];
      end
    end
    if (m_boot || m_cnt == flen(m_sel, m_dual) - 1) begin
      m_boot = 0; m_cnt = 0;
      m_sel = word_sel; m_msb = msb_first; m_dual = dual_rate;
      for (int k = 0; k < NC; k++) m_words[k] = words_in[k*WW +: WW];
    end else begin
      m_cnt++;
    end
  endtask

  task automatic compare();
    string lt;
    lt = e_reset ? "R9" : (m_dual ? "R2/R4/R8/R10" : "R1/R2/R3/R8/R10");
    vectors++;
    if (lane_out !== e_lane) begin
      errors++;
      $display("FAIL %s lane_out got %h expected %h", lt, lane_out, e_lane);
    end
    vectors++;
    if (lane_pd !== e_pd) begin
      errors++;
      $display("FAIL %s lane_pd got %h expected %h", e_reset ? "R9" : "R5", lane_pd, e_pd);
    end
    vectors++;
    if (bclk_out !== e_bclk) begin
      errors++;
      $display("FAIL %s bclk_out got %b expected %b", e_reset ? "R9" : "R6", bclk_out, e_bclk);
    end
    vectors++;
    if (fclk_out !== e_fclk) begin
      errors++;
      $display("FAIL %s fclk_out got %b expected %b", e_reset ? "R9" : "R7", fclk_out, e_fclk);
    end
  endtask

  // one cycle: check previous prediction, drive, predict the next edge
  task automatic cycle(bit do_rst, bit chg_cfg, int sel, bit msb, bit dual);
    @(negedge clk);
    compare();
    rst = do_rst;
    for (int k = 0; k < NC; k++) words_in[k*WW +: WW] = WW'($urandom);
    if (chg_cfg) begin
      word_sel = 2'(sel); msb_first = msb; dual_rate = dual;
    end
    model_step();
  endtask

  initial begin
    rst = 1; words_in = '0; word_sel = 0; msb_first = 0; dual_rate = 0;
    e_lane = '0; e_pd = '0; e_bclk = 0; e_fclk = 0; e_reset = 1;
    m_boot = 1; m_cnt = 0; m_sel = 0; m_msb = 0; m_dual = 0;
    // R9: outputs stay zero through reset
    repeat (4) cycle(1, 0, 0, 0, 0);
    for (int c = 0; c < 16; c++) begin
      // R1 R2 R3 R4: every word size, order and packing mode
      cycle(0, 1, c % 4, (c / 4) % 2, c / 8);
      for (int n = 0; n < 90; n++) begin
        // R8: settings flip mid-frame; only frame starts take them
        bit flip = ($urandom % 23) == 0;
        cycle(0, flip, $urandom % 4, $urandom % 2, $urandom % 2);
        if (flip) cycle(0, 1, c % 4, (c / 4) % 2, c / 8);
      end
      if (c == 9) begin
        // R9: restart after a mid-run reset
        cycle(1, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0);
      end
    end
    repeat (40) cycle(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule